// File: doc/BRIEF.md
# Sixteen-Line GPIO Block with Per-Line Interrupt Styles

This block gives software sixteen general-purpose pins behind a small 32-bit register bus. Each pin can drive a value or be sampled as an input. Incoming pin levels pass through a two-stage synchroniser. The synchronised value feeds a readable input register and a per-line event detector.

Every line carries a 3-bit style code. The code selects a level condition (high or low), a single edge (rising or falling) or any transition. Codes 5 to 7 switch detection off for that line. Detected events are latched in a sticky status register, and software clears it by writing ones. The status bits of lines 0 to 12 appear directly as active-high interrupt levels. Lines 13 to 15 latch status but have no interrupt output.

The bus uses single-cycle write and read strobes with a byte address. Only word-aligned accesses (address bits 1:0 equal to zero) take effect. Read data is registered and is valid on the cycle after the read strobe. The word offsets are: output data 0x00, output enable 0x04, input data 0x08, status 0x0C, styles of lines 0–7 at 0x10, styles of lines 8–15 at 0x14, clock control 0x18 and debounce select 0x1C.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the block is in this state: output data is 0, the output-enable register (0x04) is 0xFFFF so `pin_oe_n` is all ones, every style field is 0, status is 0 and `irq_out` is 0.
- R2: A 1 in bit n of 0x04 makes line n an input, so `pin_oe_n[n]` is 1. A 0 drives the line, and `pin_out` always carries the output data register (0x00). Both registers read back their written values in bits 15:0.
- R3: A read of 0x08 returns the synchronised pins in bits 15:0, with bits 31:16 reading 0. A pin change is not seen by a read whose strobe comes in the cycle right after the change.
- R4: The style of line n is the 3-bit field at bit 3·(n mod 8). Lines 0–7 use register 0x10 and lines 8–15 use 0x14. Bits 31:24 of both registers read as 0.
- R5: With style 0 (level high) or style 1 (level low), the status bit is set again on every cycle in which the level holds. A write-one-to-clear therefore takes effect only once the pin is inactive.
- R6: Style 2 sets status on a synchronised 0→1 change only. Style 3 sets status on a 1→0 change only.
- R7: Style 4 sets status on every change of the synchronised pin in either direction.
- R8: Style codes 5, 6 and 7 never set status.
- R9: Writing 0x0C clears each status bit written as 1. Bits written as 0 keep their value. If a new event arrives in the same cycle as the clear, the set wins.
- R10: `irq_out[n]` equals status bit n for lines 0–12. Lines 13–15 latch status (visible at 0x0C) but drive no interrupt.
- R11: The clock-control (0x18) and debounce-select (0x1C) registers reset to 0, read back the full 32-bit word last written, and have no effect on pins or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data toward the pads |
| pin_oe_n | output | 16 | Active-low pad drive enable (1 = input) |
| irq_out | output | 13 | Active-high interrupt levels of lines 0–12 |

## Verification
The embedded properties watch every cycle for four things. A status bit never drops without a status write. A write of ones clears exactly the written bits unless an event arrives in the same cycle. A level-style line that sees its active level always has status set on the next cycle. A disabled style never produces an event. The directed scenarios cover what needs a stimulus history: single-edge and any-edge selectivity, how a clear behaves while a level persists, the field packing across the two style registers, the synchroniser latency on readback, and the absence of an interrupt output on lines above 12.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int STY_W  = 3;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [STY_W-1:0] {
    STY_LVL_HI = 3'd0,
    STY_LVL_LO = 3'd1,
    STY_RISE   = 3'd2,
    STY_FALL   = 3'd3,
    STY_ANY    = 3'd4
  } sty_e;

  // word index = byte address [4:2]
  localparam logic [2:0] REG_DOUT   = 3'd0;
  localparam logic [2:0] REG_OEN    = 3'd1;
  localparam logic [2:0] REG_DIN    = 3'd2;
  localparam logic [2:0] REG_STAT   = 3'd3;
  localparam logic [2:0] REG_STY_LO = 3'd4;
  localparam logic [2:0] REG_STY_HI = 3'd5;
  localparam logic [2:0] REG_CLKC   = 3'd6;
  localparam logic [2:0] REG_DBSEL  = 3'd7;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_evt.sv
module gpio_evt
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LINES-1:0]            smp,
  input  logic [LINES-1:0][STY_W-1:0] sty,
  output logic [LINES-1:0]            evt
);

  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic rise, fall, hit;

      always_comb begin
        rise = smp[g] & ~prev_q[g];
        fall = ~smp[g] & prev_q[g];
        case (sty[g])
          STY_LVL_HI: hit = smp[g];
          STY_LVL_LO: hit = ~smp[g];
          STY_RISE:   hit = rise;
          STY_FALL:   hit = fall;
          STY_ANY:    hit = rise | fall;
          default:    hit = 1'b0;
        endcase
      end

      assign evt[g] = hit;

      AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (sty[g] > 3'd4) |-> !evt[g]); // R8
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int IRQ_LINES   = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe_n,
  output logic [IRQ_LINES-1:0] irq_out
);

  localparam int LPS = 8; // lines per style register

  logic [2:0]                      word;
  logic                            aligned, wr_ok, rd_ok, wr_sty;
  logic [NUM_LINES-1:0]            dout_q, oen_q, stat_q, stat_clr;
  logic [NUM_LINES-1:0][STY_W-1:0] sty_q;
  logic [DATA_W-1:0]               clkc_q, dbs_q, rd_val;
  logic [NUM_LINES-1:0]            smp, evt;

  assign word    = bus_addr[4:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr & aligned;
  assign rd_ok   = bus_rd & aligned;
  assign wr_sty  = wr_ok & ((word == REG_STY_LO) | (word == REG_STY_HI));

  gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(smp)
  );

  gpio_evt #(.LINES(NUM_LINES)) u_evt (
    .clk(clk), .rst(rst), .smp(smp), .sty(sty_q), .evt(evt)
  );

  assign stat_clr = (wr_ok && word == REG_STAT) ? bus_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      oen_q  <= '1;
      sty_q  <= '0;
      clkc_q <= '0;
      dbs_q  <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | evt;
      if (wr_ok) begin
        case (word)
          REG_DOUT:  dout_q <= bus_wdata[NUM_LINES-1:0];
          REG_OEN:   oen_q  <= bus_wdata[NUM_LINES-1:0];
          REG_CLKC:  clkc_q <= bus_wdata;
          REG_DBSEL: dbs_q  <= bus_wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < NUM_LINES; i++) begin
        if (wr_sty && (i / LPS) == int'(word[0])) begin
          sty_q[i] <= bus_wdata[(i % LPS)*STY_W +: STY_W];
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (word)
      REG_DOUT:  rd_val[NUM_LINES-1:0] = dout_q;
      REG_OEN:   rd_val[NUM_LINES-1:0] = oen_q;
      REG_DIN:   rd_val[NUM_LINES-1:0] = smp;
      REG_STAT:  rd_val[NUM_LINES-1:0] = stat_q;
      REG_STY_LO, REG_STY_HI: begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if ((i / LPS) == int'(word[0])) begin
            rd_val[(i % LPS)*STY_W +: STY_W] = sty_q[i];
          end
        end
      end
      REG_CLKC:  rd_val = clkc_q;
      REG_DBSEL: rd_val = dbs_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rd_val;
  end

  assign pin_out  = dout_q;
  assign pin_oe_n = oen_q;
  assign irq_out  = stat_q[IRQ_LINES-1:0];

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && word == REG_STAT) |=>
      ((stat_q & $past(bus_wdata[NUM_LINES-1:0] & ~evt)) == '0)); // R9

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_ok && word == REG_STAT) |=>
      ((stat_q & $past(stat_q)) == $past(stat_q))); // R9

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
      AST_LEVEL_RESETS: assert property (@(posedge clk) disable iff (rst)
        (sty_q[g] == 3'd0 && smp[g]) |=> stat_q[g]); // R5
      AST_LEVEL_LO_RESETS: assert property (@(posedge clk) disable iff (rst)
        (sty_q[g] == 3'd1 && !smp[g]) |=> stat_q[g]); // R5
    end
  endgenerate

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe_n;
  logic [12:0] irq_out;

  integer n_run = 0;
  integer n_fail = 0;
  bit     done = 1'b0;

  localparam logic [4:0] A_DOUT = 5'h00, A_OEN = 5'h04, A_DIN = 5'h08, A_STAT = 5'h0C,
                         A_STLO = 5'h10, A_STHI = 5'h14, A_CLKC = 5'h18, A_DBS = 5'h1C;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  // R4: all fields 7 except line k of the group set to code
  function automatic logic [31:0] sty_word(input int k, input logic [2:0] code);
    logic [31:0] w;
    w = 32'h00FF_FFFF & ~(32'h7 << (3*k));
    return w | (32'(code) << (3*k));
  endfunction

  task automatic all_off;
    wr(A_STLO, 32'h00FF_FFFF);
    wr(A_STHI, 32'h00FF_FFFF);
    wr(A_STAT, 32'h0000_FFFF);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_out", 32'(pin_out), 32'h0);
    chk("R1 pin_oe_n", 32'(pin_oe_n), 32'hFFFF);
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_STLO, d); chk("R1 style lo", d, 32'h0);
    rd(A_OEN, d);  chk("R1 oen readback", d, 32'hFFFF);
    rd(A_CLKC, d); chk("R11 clkc reset", d, 32'h0);
  endtask

  task automatic t_style_pack;
    logic [31:0] d;
    wr(A_STLO, 32'hFFFF_FFFF);
    rd(A_STLO, d); chk("R4 upper bits zero", d, 32'h00FF_FFFF);
    wr(A_STHI, sty_word(1, 3'd2));
    rd(A_STHI, d); chk("R4 line9 field", d, 32'h00FF_FFD7);
    rd(A_STLO, d); chk("R4 groups independent", d, 32'h00FF_FFFF);
    all_off();
  endtask

  task automatic t_output;
    logic [31:0] d;
    wr(A_DOUT, 32'h0000_00A5);
    wr(A_OEN,  32'h0000_FF00);
    chk("R2 pin_out", 32'(pin_out), 32'h00A5);
    chk("R2 pin_oe_n", 32'(pin_oe_n), 32'hFF00);
    rd(A_DOUT, d); chk("R2 dout readback", d, 32'h00A5);
    rd(A_OEN, d);  chk("R2 oen readback", d, 32'hFF00);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk);
    pin_in = 16'hA5C3;
    rd(A_DIN, d); chk("R3 sync latency", d, 32'h0);
    repeat (3) @(negedge clk);
    rd(A_DIN, d); chk("R3 input readback", d, 32'h0000_A5C3);
    set_pins(16'h0);
    wr(A_STAT, 32'hFFFF);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(A_STLO, sty_word(1, 3'd0));
    set_pins(16'h0002);
    rd(A_STAT, d); chk("R5 level high sets", d, 32'h0002);
    chk("R10 irq line1", 32'(irq_out), 32'h0002);
    wr(A_STAT, 32'h0002);
    rd(A_STAT, d); chk("R5 clear ineffective while high", d, 32'h0002);
    set_pins(16'h0);
    wr(A_STAT, 32'h0002);
    rd(A_STAT, d); chk("R5 clear after release", d, 32'h0);
    chk("R5 irq dropped", 32'(irq_out), 32'h0);
    wr(A_STLO, sty_word(6, 3'd1));
    repeat (2) @(negedge clk);
    rd(A_STAT, d); chk("R5 level low sets", d, 32'h0040);
    wr(A_STAT, 32'h0040);
    rd(A_STAT, d); chk("R5 low clear ineffective", d, 32'h0040);
    set_pins(16'h0040);
    wr(A_STAT, 32'h0040);
    rd(A_STAT, d); chk("R5 low cleared when high", d, 32'h0);
    set_pins(16'h0);
    all_off();
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(A_STLO, sty_word(3, 3'd2));
    set_pins(16'h0008);
    rd(A_STAT, d); chk("R6 rise sets", d, 32'h0008);
    wr(A_STAT, 32'h0008);
    rd(A_STAT, d); chk("R6 rise cleared while high", d, 32'h0);
    set_pins(16'h0);
    rd(A_STAT, d); chk("R6 fall ignored by rise", d, 32'h0);
    wr(A_STLO, sty_word(4, 3'd3));
    set_pins(16'h0010);
    rd(A_STAT, d); chk("R6 rise ignored by fall", d, 32'h0);
    set_pins(16'h0);
    rd(A_STAT, d); chk("R6 fall sets", d, 32'h0010);
    wr(A_STAT, 32'hFFFF);
    wr(A_STLO, sty_word(5, 3'd4));
    set_pins(16'h0020);
    rd(A_STAT, d); chk("R7 any edge rise", d, 32'h0020);
    wr(A_STAT, 32'h0020);
    set_pins(16'h0);
    rd(A_STAT, d); chk("R7 any edge fall", d, 32'h0020);
    all_off();
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    for (int c = 5; c < 8; c++) begin
      wr(A_STLO, sty_word(7, 3'(c)));
      set_pins(16'h0080);
      set_pins(16'h0);
      rd(A_STAT, d); chk("R8 disabled code silent", d, 32'h0);
    end
    all_off();
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(A_STLO, sty_word(3, 3'd2) & sty_word(5, 3'd2));
    set_pins(16'h0028);
    rd(A_STAT, d); chk("R9 both set", d, 32'h0028);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R9 zero write keeps", d, 32'h0028);
    wr(A_STAT, 32'h0008);
    rd(A_STAT, d); chk("R9 partial clear", d, 32'h0020);
    chk("R10 irq after partial clear", 32'(irq_out), 32'h0020);
    set_pins(16'h0);
    all_off();
  endtask

  task automatic t_upper;
    logic [31:0] d;
    wr(A_STHI, sty_word(6, 3'd2) & sty_word(4, 3'd2));
    set_pins(16'h4000);
    rd(A_STAT, d); chk("R10 line14 latches", d, 32'h4000);
    chk("R10 line14 no irq", 32'(irq_out), 32'h0);
    set_pins(16'h5000);
    chk("R10 line12 irq", 32'(irq_out), 32'h1000);
    set_pins(16'h0);
    all_off();
  endtask

  task automatic t_aux;
    logic [31:0] d;
    wr(A_CLKC, 32'h1234_5678);
    wr(A_DBS, 32'hABCD_0001);
    rd(A_CLKC, d); chk("R11 clkc readback", d, 32'h1234_5678);
    rd(A_DBS, d);  chk("R11 dbsel readback", d, 32'hABCD_0001);
    chk("R11 pins unaffected", 32'(pin_out), 32'h00A5);
    chk("R11 irq unaffected", 32'(irq_out), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_style_pack();
    t_output();
    t_input();
    t_level();
    t_edges();
    t_disabled();
    t_w1c();
    t_upper();
    t_aux();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule